// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary32 operands and returns a binary32 product together with three exception flags. Each operand is split into its sign, its 8-bit biased exponent and its 23-bit fraction. Nonzero finite operands get their hidden leading one back, giving 24-bit significands. The two significands are multiplied into a 48-bit product. Because both factors lie in [1,2), the product lies in [1,4), so at most one right shift normalizes it. The result is then rounded to nearest with ties to even, checked for exponent overflow and underflow, and packed.

The arithmetic is purely combinational. One register stage at the output holds the packed word and the flags, so a result appears exactly one clock after its operands. An operand whose exponent field is zero is treated as a zero, so subnormal inputs are flushed. Results too small to represent become signed zero. Round-to-nearest-even is the only rounding mode.

Top module: `fpm_mul32`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high. A synchronous reset clears `res_valid`, `res_word` and all three flags to 0.
- R2: For every result that is not NaN, bit 31 of `res_word` equals the XOR of bit 31 of the two operands.
- R3: For two normal operands, the result exponent field is exp_a + exp_b − 127. It is one higher when the significand product is 2.0 or more. In that case the product is shifted right one place before rounding.
- R4: Rounding keeps 24 significand bits. It rounds up when the first dropped bit is 1 and either any lower dropped bit is 1 or the kept LSB is 1 (ties go to even).
- R5: If rounding carries out of the 24-bit significand, the fraction becomes 0 and the exponent is incremented once more. Example: 0x3FFFFFFE × 0x3F800001 = 0x40000000.
- R6: When the final biased exponent is 255 or more, the result is signed infinity (exponent 0xFF, fraction 0) and `flag_ovf` is 1.
- R7: When the final biased exponent is 0 or less, the result is signed zero and `flag_unf` is 1.
- R8: An operand with exponent field 0 counts as zero, whatever its fraction bits. Zero times a finite value gives signed zero with no flag set.
- R9: Infinity (exponent 0xFF, fraction 0) times a nonzero finite value or an infinity gives signed infinity with no flag set.
- R10: A NaN operand (exponent 0xFF, fraction nonzero), or zero times infinity, gives 0x7FC00000 with `flag_inv` = 1.
- R11: At most one of `flag_inv`, `flag_ovf` and `flag_unf` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| res_valid | output | 1 | Result present this cycle |
| res_word | output | 32 | Packed binary32 product |
| flag_inv | output | 1 | Invalid operation (NaN result) |
| flag_ovf | output | 1 | Exponent overflow to infinity |
| flag_unf | output | 1 | Exponent underflow to zero |

## Verification
The hardest case to reach from the ports is the rounding carry-out of R5. It needs a significand product that sits just below a power of two, with all 24 kept bits set and a dropped guard bit of 1. Random operands almost never produce this. The bench therefore uses a directed pair chosen by factoring: a significand of 2^24−2 times one of 2^23+1 gives 2^47−2. A matched pair of half-way ties checks both directions of the even rule. Exponent pairs placed just past each limit exercise overflow and underflow. Random operands confined to safe exponents, plus fully random words, cover the normal path against an integer reference model.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int XW     = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fpm_cls_e;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        fpm_cls_e          cls;
    } fpm_opnd_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              inv;
        logic              ovf;
        logic              unf;
    } fpm_res_t;

    function automatic logic [WORD_W-1:0] fpm_pack(input logic s,
                                                   input logic [EXP_W-1:0] e,
                                                   input logic [FRAC_W-1:0] f);
        return {s, e, f};
    endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fpm_opnd_t         opnd
);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;

    assign e = word[WORD_W-2 -: EXP_W];
    assign f = word[FRAC_W-1:0];

    always_comb begin
        opnd.sgn = word[WORD_W-1];
        opnd.exp = e;
        opnd.sig = {1'b1, f};
        if (e == '0) begin
            opnd.cls = CLS_ZERO;
            opnd.sig = '0;
        end else if (e == EXP_W'(EXP_MAX)) begin
            opnd.cls = (f == '0) ? CLS_INF : CLS_NAN;
        end else begin
            opnd.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fpm_sig_round.sv
module fpm_sig_round
    import fpm_pkg::*;
(
    input  logic [SIG_W-1:0]     sig_a,
    input  logic [SIG_W-1:0]     sig_b,
    input  logic [EXP_W-1:0]     exp_a,
    input  logic [EXP_W-1:0]     exp_b,
    output logic [FRAC_W-1:0]    frac,
    output logic signed [XW-1:0] exp_out
);
    logic [PROD_W-1:0] prod;
    logic              hi;
    logic [SIG_W-1:0]  keep;
    logic              guard;
    logic              sticky;
    logic              up;
    logic [SIG_W:0]    rnd;
    logic signed [XW-1:0] exp_sum;

    assign prod = PROD_W'(sig_a) * PROD_W'(sig_b);
    assign hi   = prod[PROD_W-1];

    always_comb begin
        if (hi) begin
            keep   = prod[PROD_W-1 -: SIG_W];
            guard  = prod[PROD_W-SIG_W-1];
            sticky = |prod[PROD_W-SIG_W-2:0];
        end else begin
            keep   = prod[PROD_W-2 -: SIG_W];
            guard  = prod[PROD_W-SIG_W-2];
            sticky = |prod[PROD_W-SIG_W-3:0];
        end
    end

    assign up  = guard & (sticky | keep[0]);
    assign rnd = {1'b0, keep} + (SIG_W+1)'(up);

    assign exp_sum = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b}) - XW'(BIAS);
    assign exp_out = exp_sum + $signed({{(XW-1){1'b0}}, hi}) + $signed({{(XW-1){1'b0}}, rnd[SIG_W]});
    assign frac    = rnd[FRAC_W-1:0];
endmodule

// File: rtl/fpm_resolve.sv
module fpm_resolve
    import fpm_pkg::*;
(
    input  fpm_opnd_t            a,
    input  fpm_opnd_t            b,
    input  logic [FRAC_W-1:0]    frac,
    input  logic signed [XW-1:0] exp_in,
    output fpm_res_t             res
);
    logic sgn;
    logic any_nan, any_inf, any_zero;

    assign sgn      = a.sgn ^ b.sgn;
    assign any_nan  = (a.cls == CLS_NAN)  || (b.cls == CLS_NAN);
    assign any_inf  = (a.cls == CLS_INF)  || (b.cls == CLS_INF);
    assign any_zero = (a.cls == CLS_ZERO) || (b.cls == CLS_ZERO);

    always_comb begin
        res = '0;
        if (any_nan || (any_inf && any_zero)) begin
            res.word = QNAN_WORD;
            res.inv  = 1'b1;
        end else if (any_inf) begin
            res.word = fpm_pack(sgn, EXP_W'(EXP_MAX), '0);
        end else if (any_zero) begin
            res.word = fpm_pack(sgn, '0, '0);
        end else if (exp_in >= XW'(EXP_MAX)) begin
            res.word = fpm_pack(sgn, EXP_W'(EXP_MAX), '0);
            res.ovf  = 1'b1;
        end else if (exp_in[XW-1] || exp_in == '0) begin
            res.word = fpm_pack(sgn, '0, '0);
            res.unf  = 1'b1;
        end else begin
            res.word = fpm_pack(sgn, exp_in[EXP_W-1:0], frac);
        end
    end
endmodule

// File: rtl/fpm_mul32.sv
module fpm_mul32
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word,
    output logic              flag_inv,
    output logic              flag_ovf,
    output logic              flag_unf
);
    fpm_opnd_t            opnd [2];
    logic [WORD_W-1:0]    words [2];
    logic [FRAC_W-1:0]    frac;
    logic signed [XW-1:0] exp_r;
    fpm_res_t             comb_res;
    fpm_res_t             res_q;

    assign words[0] = op_a;
    assign words[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fpm_unpack u_unpack (.word(words[i]), .opnd(opnd[i]));
    end

    fpm_sig_round u_round (
        .sig_a  (opnd[0].sig),
        .sig_b  (opnd[1].sig),
        .exp_a  (opnd[0].exp),
        .exp_b  (opnd[1].exp),
        .frac   (frac),
        .exp_out(exp_r)
    );

    fpm_resolve u_resolve (
        .a     (opnd[0]),
        .b     (opnd[1]),
        .frac  (frac),
        .exp_in(exp_r),
        .res   (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) res_q <= comb_res;
        end
    end

    assign res_word = res_q.word;
    assign flag_inv = res_q.inv;
    assign flag_ovf = res_q.ovf;
    assign flag_unf = res_q.unf;
endmodule

// File: rtl/fpm_mul32_chk.sv
module fpm_mul32_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        res_valid,
    input logic [31:0] res_word,
    input logic        flag_inv,
    input logic        flag_ovf,
    input logic        flag_unf
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    // R2
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a[30:23] != 8'hFF && op_b[30:23] != 8'hFF)
        |=> res_word[31] == $past(op_a[31] ^ op_b[31]));
    // R10
    invalid_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && flag_inv) |-> res_word == 32'h7FC00000);
    // R6
    overflow_inf_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && flag_ovf) |-> res_word[30:0] == 31'h7F800000);
    // R7
    underflow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && flag_unf) |-> res_word[30:0] == 31'h0);
    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_inv, flag_ovf, flag_unf}));
endmodule

bind fpm_mul32 fpm_mul32_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .res_word(res_word),
    .flag_inv(flag_inv), .flag_ovf(flag_ovf), .flag_unf(flag_unf)
);

// File: tb/tb_fpm_mul32.sv
module tb_fpm_mul32;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        res_valid;
    logic [31:0] res_word;
    logic        flag_inv, flag_ovf, flag_unf;

    int n_cmp = 0;
    int n_bad = 0;
    logic [34:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    fpm_mul32 dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .res_valid(res_valid), .res_word(res_word),
        .flag_inv(flag_inv), .flag_ovf(flag_ovf), .flag_unf(flag_unf)
    );

    // Integer reference model: {word, inv, ovf, unf}
    function automatic logic [34:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        int ea = int'(a[30:23]);
        int eb = int'(b[30:23]);
        bit s  = a[31] ^ b[31];
        bit za = (ea == 0), zb = (eb == 0);
        bit ia = (ea == 255) && (a[22:0] == 0), ib = (eb == 255) && (b[22:0] == 0);
        bit na = (ea == 255) && (a[22:0] != 0), nb = (eb == 255) && (b[22:0] != 0);
        longint ma, mb, prod, keep, rem, half;
        int e, sh;
        if (na || nb || ((ia || ib) && (za || zb))) return {32'h7FC00000, 3'b100};
        if (ia || ib) return {s, 8'hFF, 23'h0, 3'b000};
        if (za || zb) return {s, 31'h0, 3'b000};
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        prod = ma * mb;
        e = ea + eb - 127;
        if (prod >= (64'sd1 <<< 47)) begin sh = 24; e++; end else sh = 23;
        keep = prod >>> sh;
        rem  = prod & ((64'sd1 <<< sh) - 1);
        half = 64'sd1 <<< (sh - 1);
        if (rem > half || (rem == half && keep[0])) keep++;
        if (keep == (64'sd1 <<< 24)) begin keep = keep >>> 1; e++; end
        if (e >= 255) return {s, 8'hFF, 23'h0, 3'b010};
        if (e <= 0)   return {s, 31'h0, 3'b001};
        return {s, e[7:0], keep[22:0], 3'b000};
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        exp_q.push_back(ref_mul(a, b));
        tag_q.push_back(tag);
    endtask

    task automatic drive_exp(input logic [31:0] a, input logic [31:0] b,
                             input logic [34:0] want, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        exp_q.push_back(want);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input logic [34:0] got, input logic [34:0] want);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            logic [34:0] got, want;
            string t;
            got = {res_word, flag_inv, flag_ovf, flag_unf};
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected result", got, 35'h0);
            end else begin
                want = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got == want, t, got, want);
                check($countones({flag_inv, flag_ovf, flag_unf}) <= 1, "R11", got, want);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check(res_valid == 0 && res_word == 0 && {flag_inv, flag_ovf, flag_unf} == 0,
                      "R1 reset", {res_word, flag_inv, flag_ovf, flag_unf}, 35'h0);
                rst = 1'b0;
                drive_exp(32'h3F800000, 32'h3F800000, {32'h3F800000, 3'b000}, "R3 one");
                drive_exp(32'h3FC00000, 32'h3FC00000, {32'h40100000, 3'b000}, "R3 norm shift");
                drive_exp(32'h40000000, 32'hC0400000, {32'hC0C00000, 3'b000}, "R2 sign");
                drive_exp(32'h3F800001, 32'h3FC00000, {32'h3FC00002, 3'b000}, "R4 tie up");
                drive_exp(32'h3F800003, 32'h3FC00000, {32'h3FC00004, 3'b000}, "R4 tie even");
                drive_exp(32'h3FFFFFFE, 32'h3F800001, {32'h40000000, 3'b000}, "R5 carry");
                drive_exp(32'h7F000000, 32'hFF000000, {32'hFF800000, 3'b010}, "R6 overflow");
                drive_exp(32'h00800000, 32'h00800000, {32'h00000000, 3'b001}, "R7 underflow");
                drive_exp(32'h80800000, 32'h00800000, {32'h80000000, 3'b001}, "R7 neg underflow");
                drive_exp(32'h007FFFFF, 32'h40000000, {32'h00000000, 3'b000}, "R8 subnormal flush");
                drive_exp(32'h80000000, 32'h40400000, {32'h80000000, 3'b000}, "R8 neg zero");
                drive_exp(32'h7F800000, 32'hBF800000, {32'hFF800000, 3'b000}, "R9 inf");
                drive_exp(32'h7F800000, 32'h7F800000, {32'h7F800000, 3'b000}, "R9 inf inf");
                drive_exp(32'h7F800000, 32'h00000000, {32'h7FC00000, 3'b100}, "R10 zero inf");
                drive_exp(32'h3F800000, 32'hFFC01234, {32'h7FC00000, 3'b100}, "R10 nan");
                idle();
                idle();
                check(res_valid == 0, "R1 idle", {res_word, 3'b000}, 35'h0);
                for (int i = 0; i < 300; i++) begin
                    logic [31:0] a, b;
                    a = $urandom;
                    b = $urandom;
                    a[30:23] = 8'(64 + ($urandom % 128));
                    b[30:23] = 8'(64 + ($urandom % 128));
                    drive(a, b, "R3 random");
                    if (i % 7 == 0) idle();
                end
                for (int i = 0; i < 300; i++) begin
                    drive($urandom, $urandom, "R4 random full");
                end
                idle();
                idle();
                check(exp_q.size() == 0, "R1 drain", 35'(exp_q.size()), 35'h0);
            end
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 35'h0, 35'h0);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule